// File: doc/BRIEF.md
# USB IN Endpoint Arming Controller

This block runs one device-side IN endpoint that sits between a local processor and a USB packet engine. The processor fills a packet buffer of up to 64 bytes. It then writes the packet length into a count register. That write arms the endpoint and sets a busy flag, which tells software to leave the buffer alone. Host IN tokens that arrive before the endpoint is armed get a NAK. The first token after arming gets a DATA response that carries the packet length. The stored bytes then stream out over a valid/ready byte interface.

When the host acknowledges the packet, the busy flag drops and a sticky interrupt flag is raised. The flag reaches the processor's interrupt line only while the endpoint's enable bit is set, and software clears it by writing one. If the host times out instead of acknowledging, the endpoint stays armed and sends the same bytes again on the next token.

Software sends a long transfer as a series of full 64-byte packets followed by one short packet. Bulk and interrupt endpoints use the same controller: only the host's polling rate differs.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset, cpu_busy, cpu_irq_pend, cpu_irq, rsp_valid and tx_valid are all 0.
- R2: A tok_in pulse while the endpoint is not armed gives a one-cycle rsp_valid on the next cycle, with rsp_kind = 1 (NAK) and rsp_len = 0. No bytes are sent.
- R3: A cpu_bc_wdata write through cpu_bc_we while cpu_busy is 0 arms the endpoint. cpu_busy reads 1 from the next cycle until the packet is acknowledged.
- R4: The first tok_in after arming gives rsp_valid on the next cycle with rsp_kind = 2 (DATA) and rsp_len equal to the armed count. Exactly that many bytes then leave on tx_data, taken from buffer addresses 0 upward in order, one per cycle with tx_valid and tx_ready both high. tx_last marks the final byte.
- R5: An hs_ack pulse after the last byte clears cpu_busy and sets cpu_irq_pend on the next cycle.
- R6: cpu_irq is 1 only while cpu_irq_pend is set and the enable bit (written by cpu_ien_we with cpu_ien_wdata, reset value 0) is 1.
- R7: A cpu_irq_clr pulse clears cpu_irq_pend on the next cycle. If an acknowledge arrives in the same cycle, the flag stays set.
- R8: A count above 64 arms a 64-byte packet. A count of 0 arms a DATA response with rsp_len = 0, no tx_valid, and a wait for hs_ack.
- R9: An hs_timeout pulse while waiting for the handshake keeps cpu_busy at 1 and cpu_irq_pend unchanged. The next tok_in resends the same length and bytes.
- R10: A count write while cpu_busy is 1 is ignored: the length and data of the pending packet stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_buf_we | input | 1 | Buffer byte write strobe |
| cpu_buf_addr | input | 6 | Buffer byte address |
| cpu_buf_wdata | input | 8 | Buffer byte data |
| cpu_bc_we | input | 1 | Count register write strobe (arms the endpoint) |
| cpu_bc_wdata | input | 8 | Packet length to arm |
| cpu_ien_we | input | 1 | Interrupt enable write strobe |
| cpu_ien_wdata | input | 1 | Interrupt enable value |
| cpu_irq_clr | input | 1 | Write-one-to-clear of the interrupt flag |
| cpu_busy | output | 1 | Endpoint armed, buffer locked |
| cpu_irq_pend | output | 1 | Sticky packet-done flag |
| cpu_irq | output | 1 | Enabled interrupt request |
| tok_in | input | 1 | Host IN token addressed to this endpoint |
| hs_ack | input | 1 | Host ACK received |
| hs_timeout | input | 1 | Handshake timeout, no ACK |
| rsp_valid | output | 1 | Token response strobe |
| rsp_kind | output | 2 | 1 = NAK, 2 = DATA |
| rsp_len | output | 7 | Data packet length |
| tx_ready | input | 1 | Transmitter takes a byte |
| tx_valid | output | 1 | Byte available |
| tx_data | output | 8 | Packet byte |
| tx_last | output | 1 | Final byte of the packet |

## Verification
The hardest case to reach is a timeout that arrives after a partly stalled byte stream, followed by a resend. On the resend, the output must restart from buffer address 0 with the original length. A count write that lands during the pending packet must not be able to change that length. The stimulus arms a packet, drives tx_ready at random so the stream stalls, and writes a different count while busy. It then drives hs_timeout instead of hs_ack and issues a second token, and compares both byte sequences with the buffer model. Zero-length packets and counts above 64 are mixed into the random passes so that the response without any bytes and the clamped length occur regularly.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;
  typedef enum logic [1:0] {
    EP_IDLE    = 2'd0,
    EP_ARMED   = 2'd1,
    EP_SEND    = 2'd2,
    EP_WAIT_HS = 2'd3
  } ep_state_e;

  localparam logic [1:0] RSP_NONE = 2'd0;
  localparam logic [1:0] RSP_NAK  = 2'd1;
  localparam logic [1:0] RSP_DATA = 2'd2;
endpackage

// File: rtl/usb_in_ep_buf.sv
module usb_in_ep_buf #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  // one enabled register per entry, no reset on storage
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk) begin
      if (ent_en) begin
        mem[g] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/usb_in_ep_seq.sv
module usb_in_ep_seq
  import usb_in_ep_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int BCW     = 8,
  localparam int AW     = $clog2(MAX_PKT),
  localparam int LW     = $clog2(MAX_PKT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bc_we,
  input  logic [BCW-1:0] bc_wdata,
  input  logic           tok_in,
  input  logic           hs_ack,
  input  logic           hs_timeout,
  input  logic           tx_ready,
  output logic           busy,
  output logic           rsp_valid,
  output logic [1:0]     rsp_kind,
  output logic [LW-1:0]  rsp_len,
  output logic [AW-1:0]  rd_addr,
  output logic           tx_valid,
  output logic           tx_last,
  output logic           ack_done
);
  ep_state_e     state_q, state_d;
  logic [LW-1:0] len_q, len_d;
  logic [LW-1:0] idx_q, idx_d;
  logic          rsp_valid_q, rsp_valid_d;
  logic [1:0]    rsp_kind_q, rsp_kind_d;
  logic [LW-1:0] rsp_len_q, rsp_len_d;
  logic          len_en, idx_en, rsp_en;
  logic [LW-1:0] bc_clamped;

  assign bc_clamped = (bc_wdata > BCW'(MAX_PKT)) ? LW'(MAX_PKT) : bc_wdata[LW-1:0];

  assign busy     = (state_q != EP_IDLE);
  assign tx_valid = (state_q == EP_SEND);
  assign tx_last  = tx_valid && (idx_q == (len_q - LW'(1)));
  assign rd_addr  = idx_q[AW-1:0];

  // next-state process
  always_comb begin
    state_d     = state_q;
    len_d       = len_q;
    idx_d       = idx_q;
    rsp_valid_d = 1'b0;
    rsp_kind_d  = rsp_kind_q;
    rsp_len_d   = rsp_len_q;
    len_en      = 1'b0;
    idx_en      = 1'b0;
    rsp_en      = 1'b0;
    ack_done    = 1'b0;
    unique case (state_q)
      EP_IDLE: begin
        if (bc_we) begin
          len_d   = bc_clamped;
          len_en  = 1'b1;
          state_d = EP_ARMED;
        end
        if (tok_in) begin
          rsp_valid_d = 1'b1;
          rsp_kind_d  = RSP_NAK;
          rsp_len_d   = '0;
          rsp_en      = 1'b1;
        end
      end
      EP_ARMED: begin
        if (tok_in) begin
          rsp_valid_d = 1'b1;
          rsp_kind_d  = RSP_DATA;
          rsp_len_d   = len_q;
          rsp_en      = 1'b1;
          idx_d       = '0;
          idx_en      = 1'b1;
          state_d     = (len_q == '0) ? EP_WAIT_HS : EP_SEND;
        end
      end
      EP_SEND: begin
        if (tx_ready) begin
          if (tx_last) begin
            state_d = EP_WAIT_HS;
          end else begin
            idx_d  = idx_q + LW'(1);
            idx_en = 1'b1;
          end
        end
      end
      EP_WAIT_HS: begin
        if (hs_ack) begin
          state_d  = EP_IDLE;
          ack_done = 1'b1;
        end else if (hs_timeout) begin
          state_d = EP_ARMED;
          idx_d   = '0;
          idx_en  = 1'b1;
        end
      end
      default: state_d = EP_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= EP_IDLE;
      len_q       <= '0;
      idx_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_kind_q  <= RSP_NONE;
      rsp_len_q   <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      if (len_en) len_q <= len_d;
      if (idx_en) idx_q <= idx_d;
      if (rsp_en) begin
        rsp_kind_q <= rsp_kind_d;
        rsp_len_q  <= rsp_len_d;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_kind  = rsp_kind_q;
  assign rsp_len   = rsp_len_q;

  // R2
  nak_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && state_q == EP_IDLE) |=> (rsp_valid && rsp_kind == RSP_NAK));

  // R3
  arm_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_we && !busy) |=> busy);

  // R4
  data_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && state_q == EP_ARMED) |=> (rsp_valid && rsp_kind == RSP_DATA && rsp_len == $past(len_q)));

  // R8
  len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (len_q <= LW'(MAX_PKT)));

  // R10
  busy_bc_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_we && busy) |=> (len_q == $past(len_q)));

  // R9
  timeout_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == EP_WAIT_HS && hs_timeout && !hs_ack) |=> (busy && !tx_valid));
endmodule

// File: rtl/usb_in_ep_irq.sv
module usb_in_ep_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_evt,
  input  logic ien_we,
  input  logic ien_wdata,
  input  logic clr,
  output logic pend,
  output logic irq
);
  logic pend_q, pend_d;
  logic ien_q;

  always_comb begin
    pend_d = pend_q;
    if (clr)     pend_d = 1'b0;
    if (ack_evt) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (ien_we) ien_q <= ien_wdata;
    end
  end

  assign pend = pend_q;
  assign irq  = pend_q && ien_q;

  // R5
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> pend_q);

  // R7
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ack_evt) |=> !pend_q);
endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl #(
  parameter int MAX_PKT = 64,
  parameter int DW      = 8,
  parameter int BCW     = 8,
  localparam int AW     = $clog2(MAX_PKT),
  localparam int LW     = $clog2(MAX_PKT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_buf_we,
  input  logic [AW-1:0]  cpu_buf_addr,
  input  logic [DW-1:0]  cpu_buf_wdata,
  input  logic           cpu_bc_we,
  input  logic [BCW-1:0] cpu_bc_wdata,
  input  logic           cpu_ien_we,
  input  logic           cpu_ien_wdata,
  input  logic           cpu_irq_clr,
  output logic           cpu_busy,
  output logic           cpu_irq_pend,
  output logic           cpu_irq,
  input  logic           tok_in,
  input  logic           hs_ack,
  input  logic           hs_timeout,
  output logic           rsp_valid,
  output logic [1:0]     rsp_kind,
  output logic [LW-1:0]  rsp_len,
  input  logic           tx_ready,
  output logic           tx_valid,
  output logic [DW-1:0]  tx_data,
  output logic           tx_last
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [AW-1:0] rd_addr;
  logic          ack_done;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  usb_in_ep_buf #(.DEPTH(MAX_PKT), .DW(DW)) u_buf (
    .clk     (clk),
    .wr_en   (cpu_buf_we),
    .wr_addr (cpu_buf_addr),
    .wr_data (cpu_buf_wdata),
    .rd_addr (rd_addr),
    .rd_data (tx_data)
  );

  usb_in_ep_seq #(.MAX_PKT(MAX_PKT), .BCW(BCW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bc_we      (cpu_bc_we),
    .bc_wdata   (cpu_bc_wdata),
    .tok_in     (tok_in),
    .hs_ack     (hs_ack),
    .hs_timeout (hs_timeout),
    .tx_ready   (tx_ready),
    .busy       (cpu_busy),
    .rsp_valid  (rsp_valid),
    .rsp_kind   (rsp_kind),
    .rsp_len    (rsp_len),
    .rd_addr    (rd_addr),
    .tx_valid   (tx_valid),
    .tx_last    (tx_last),
    .ack_done   (ack_done)
  );

  usb_in_ep_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ack_evt   (ack_done),
    .ien_we    (cpu_ien_we),
    .ien_wdata (cpu_ien_wdata),
    .clr       (cpu_irq_clr),
    .pend      (cpu_irq_pend),
    .irq       (cpu_irq)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (!cpu_busy && !cpu_irq_pend && !rsp_valid && !tx_valid));
endmodule

// File: tb/sim_usb_in_ep_ctrl.sv
module sim_usb_in_ep_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_buf_we;
  logic [5:0] cpu_buf_addr;
  logic [7:0] cpu_buf_wdata;
  logic       cpu_bc_we;
  logic [7:0] cpu_bc_wdata;
  logic       cpu_ien_we;
  logic       cpu_ien_wdata;
  logic       cpu_irq_clr;
  logic       cpu_busy, cpu_irq_pend, cpu_irq;
  logic       tok_in, hs_ack, hs_timeout;
  logic       rsp_valid;
  logic [1:0] rsp_kind;
  logic [6:0] rsp_len;
  logic       tx_ready, tx_valid, tx_last;
  logic [7:0] tx_data;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_in_ep_ctrl u0 (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clamp_len(int v);
    return (v > 64) ? 64 : v;
  endfunction

  task automatic write_buf(int a, int d);
    cpu_buf_we = 1'b1; cpu_buf_addr = 6'(a); cpu_buf_wdata = 8'(d);
    @(negedge clk);
    cpu_buf_we = 1'b0;
  endtask

  task automatic fill(int n);
    for (int i = 0; i < n && i < 64; i++) begin
      model[i] = 8'($urandom);
      write_buf(i, model[i]);
    end
  endtask

  task automatic write_bc(int v);
    cpu_bc_we = 1'b1; cpu_bc_wdata = 8'(v);
    @(negedge clk);
    cpu_bc_we = 1'b0;
  endtask

  task automatic token(string req, int kind, int len);
    tok_in = 1'b1;
    @(negedge clk);
    tok_in = 1'b0;
    check({req, " rsp_valid"}, int'(rsp_valid), 1);
    check({req, " rsp_kind"}, int'(rsp_kind), kind);
    check({req, " rsp_len"}, int'(rsp_len), len);
  endtask

  task automatic recv(string req, int n);
    int cnt = 0;
    int guard = 0;
    while (cnt < n && guard < 1000) begin
      tx_ready = ($urandom % 4) != 0;
      #1;
      if (tx_valid && tx_ready) begin
        check({req, " byte"}, int'(tx_data), int'(model[cnt]));
        check({req, " last"}, int'(tx_last), int'(cnt == n - 1));
        cnt++;
      end else begin
        check({req, " valid while sending"}, int'(tx_valid), 1);
      end
      guard++;
      @(negedge clk);
    end
    tx_ready = 1'b0;
    check({req, " byte count"}, cnt, n);
    check({req, " stream done"}, int'(tx_valid), 0);
    check({req, " busy held"}, int'(cpu_busy), 1);
  endtask

  task automatic ack(string req);
    hs_ack = 1'b1;
    @(negedge clk);
    hs_ack = 1'b0;
    check({req, " busy cleared"}, int'(cpu_busy), 0);
    check({req, " irq pending"}, int'(cpu_irq_pend), 1);
  endtask

  task automatic clr_irq();
    cpu_irq_clr = 1'b1;
    @(negedge clk);
    cpu_irq_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    cpu_buf_we = 0; cpu_buf_addr = 0; cpu_buf_wdata = 0;
    cpu_bc_we = 0; cpu_bc_wdata = 0; cpu_ien_we = 0; cpu_ien_wdata = 0;
    cpu_irq_clr = 0; tok_in = 0; hs_ack = 0; hs_timeout = 0; tx_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 busy", int'(cpu_busy), 0);
    check("R1 pend", int'(cpu_irq_pend), 0);
    check("R1 irq", int'(cpu_irq), 0);
    check("R1 rsp_valid", int'(rsp_valid), 0);
    check("R1 tx_valid", int'(tx_valid), 0);

    // R2 unarmed tokens get NAK
    token("R2", 1, 0);
    @(negedge clk);
    check("R2 pulse one cycle", int'(rsp_valid), 0);
    check("R2 no bytes", int'(tx_valid), 0);

    // R6 enable on
    cpu_ien_we = 1; cpu_ien_wdata = 1;
    @(negedge clk);
    cpu_ien_we = 0;

    // R3 R4 R5: 220 bytes as 64,64,64,28
    for (int p = 0; p < 4; p++) begin
      n = (p < 3) ? 64 : 28;
      fill(n);
      token("R2 before arm", 1, 0);
      write_bc(n);
      check("R3 busy after arm", int'(cpu_busy), 1);
      token("R4", 2, n);
      recv("R4", n);
      ack("R5");
      check("R6 irq enabled", int'(cpu_irq), 1);
      clr_irq();
      check("R7 cleared", int'(cpu_irq_pend), 0);
      check("R6 irq low after clear", int'(cpu_irq), 0);
    end

    // R9 R10 timeout retransmit, count write while busy
    fill(20);
    write_bc(20);
    write_bc(5);
    token("R10", 2, 20);
    recv("R10", 20);
    write_bc(33);
    hs_timeout = 1'b1;
    @(negedge clk);
    hs_timeout = 1'b0;
    check("R9 still busy", int'(cpu_busy), 1);
    check("R9 no irq", int'(cpu_irq_pend), 0);
    token("R9 resend", 2, 20);
    recv("R9 resend", 20);
    // R7 ack and clear in same cycle: set wins
    cpu_irq_clr = 1'b1;
    ack("R7 set wins");
    cpu_irq_clr = 1'b0;
    clr_irq();

    // R8 clamp and zero length
    fill(64);
    write_bc(200);
    token("R8 clamp", 2, 64);
    recv("R8 clamp", 64);
    ack("R8 clamp");
    clr_irq();
    write_bc(0);
    token("R8 zero", 2, 0);
    check("R8 zero no bytes", int'(tx_valid), 0);
    check("R8 zero busy", int'(cpu_busy), 1);
    ack("R8 zero");

    // R6 enable off hides the request
    cpu_ien_we = 1; cpu_ien_wdata = 0;
    @(negedge clk);
    cpu_ien_we = 0;
    check("R6 pend kept", int'(cpu_irq_pend), 1);
    check("R6 irq masked", int'(cpu_irq), 0);
    clr_irq();

    // random passes
    for (int k = 0; k < 12; k++) begin
      n = $urandom % 80;
      fill(clamp_len(n));
      write_bc(n);
      token("R4 rand", 2, clamp_len(n));
      recv("R4 rand", clamp_len(n));
      if ($urandom % 2 == 1) begin
        hs_timeout = 1'b1;
        @(negedge clk);
        hs_timeout = 1'b0;
        token("R9 rand", 2, clamp_len(n));
        recv("R9 rand", clamp_len(n));
      end
      ack("R5 rand");
      clr_irq();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule